// File: doc/BRIEF.md
# Command-Gated Serial Register Port

This block is the device side of a five-pin serial link: chip select, serial clock, data in, data out and an active-low data-ready line. Every transaction opens with an 8-bit command byte. The command byte picks a read or a write and a 4-bit register address. A data phase follows. It is 8 bits long for the status and control registers and 24 bits long for the conversion result. The port then returns to waiting for the next command. All pins are oversampled by the system clock, so the block lives entirely in the `clk` domain.

Conversion results arrive through a strobe input, which carries a channel number and a 24-bit value. The port loads the value into its result register and sets a per-channel ready flag. The ready line goes high for one cycle before the result register changes, and then goes low. It goes high again when a result read completes. The two ready flags can also be read from a status register. This lets a host poll for results with chip select tied low permanently (three-wire use).

The state machine has three states. `ST_CMD` collects the command byte. `ST_WR` collects 8 write bits. `ST_RD` shifts the read word out. These are the transitions:
- `ST_CMD` goes to `ST_WR` or `ST_RD` after a valid command byte.
- An ignored command byte leaves the port in `ST_CMD`.
- `ST_WR` and `ST_RD` return to `ST_CMD` when their last bit is done.
- A deasserted chip select forces `ST_CMD` from any state.

Top module: `cmdgated_serial_port`

## Requirements
- R1: After reset the port is in the command state and treats the next 8 bits as a command byte; `rdy_n` is 1 and `sdo` is 0 until a read data phase begins.
- R2: Command byte layout: bit 7 must be 0, otherwise the byte is ignored and the next 8 bits are again taken as a command. Bit 6 is 1 for read and 0 for write. Bits 3:0 are the register address.
- R3: Addresses 1 to 3 are 8-bit read/write control registers that reset to 0. Address 0 is the status register and address 4 is the result register; both are read-only. Any other address reads as 0. Writes to read-only or unused addresses take 8 bits and have no effect. After each data phase the port expects a new command.
- R4: A strobe captured on `res_strobe` loads `res_data` into the result register and sets the ready flag of channel `res_chan`. `rdy_n` is 0 from the second clock edge after the strobe. Strobes must be at least two cycles apart.
- R5: When the 24th bit of a result read (address 4) is sampled, `rdy_n` goes to 1 and both ready flags clear.
- R6: On the clock edge that captures a strobe, `rdy_n` is driven to 1. The result register changes only on the following edge, while `rdy_n` is 1.
- R7: Reading the result again without a new strobe returns the same 24-bit value.
- R8: The status register (address 0) returns channel 0's ready flag in bit 0 and channel 1's in bit 1, with the other bits 0. Reading it does not clear the flags, and back-to-back transactions work with `cs_n` held low throughout.
- R9: Data moves MSB first. `sdi` is sampled on rising `sclk` edges, `sdo` changes on falling edges, and the MSB of a read word is already on `sdo` when the data phase begins, before any falling edge.
- R10: Raising `cs_n` before a data phase completes aborts the transaction without writing anything, and the port returns to the command state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select, or frame sync |
| sclk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data into the port |
| sdo | output | 1 | Serial data out of the port |
| rdy_n | output | 1 | Active-low result-ready line |
| res_strobe | input | 1 | One-cycle pulse: a new conversion result is present |
| res_chan | input | 1 | Channel of the strobed result |
| res_data | input | 24 | Strobed conversion result |

## Verification
The bench goes after the following corner cases:
- A command byte with bit 7 set, followed by a valid command in the same frame. A port that failed to drop the ignored byte would treat the second byte as data and return the wrong register.
- A write cut short by chip select. A port that failed to abort would corrupt a control register or shift out of step with the next command.
- The single cycle after a strobe, when `rdy_n` must read 1. A port without the pre-update stage shows 0 there.
- The MSB sampled before the first data-phase falling edge. A port that shifts on that edge loses the top bit.
- Repeat result reads and status reads in three-wire frames. These expose flags cleared by the wrong access or result words that change without a strobe.

// File: rtl/csp_pkg.sv
package csp_pkg;
    typedef enum logic [1:0] {
        ST_CMD = 2'd0,
        ST_WR  = 2'd1,
        ST_RD  = 2'd2
    } csp_state_t;

    localparam int CMD_W     = 8;
    localparam int ADDR_W    = 4;
    localparam int RES_W     = 24;
    localparam int CNT_W     = $clog2(RES_W) + 1;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 4'd0;
    localparam logic [ADDR_W-1:0] RES_ADDR  = 4'd4;
endpackage

// File: rtl/csp_pin_sync.sv
module csp_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= {(STAGES+1){RST_VAL}};
        else        sh <= {sh[STAGES-1:0], pin};
    end

    assign level = sh[STAGES-1];
    assign rise  = sh[STAGES-1] & ~sh[STAGES];
    assign fall  = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/csp_ready_trk.sv
module csp_ready_trk #(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic          chan,
    input  logic [DW-1:0] din,
    input  logic          read_done,
    output logic [DW-1:0] result,
    output logic [1:0]    flags,
    output logic          upd,
    output logic          rdy_n
);
    logic [DW-1:0] hold;
    logic          hold_ch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold    <= '0;
            hold_ch <= 1'b0;
            result  <= '0;
            flags   <= '0;
            upd     <= 1'b0;
            rdy_n   <= 1'b1;
        end else begin
            if (read_done) begin
                flags <= '0;
                rdy_n <= 1'b1;
            end
            if (upd) begin
                result         <= hold;
                flags[hold_ch] <= 1'b1;
                rdy_n          <= 1'b0;
                upd            <= 1'b0;
            end else if (strobe) begin
                hold    <= din;
                hold_ch <= chan;
                upd     <= 1'b1;
                rdy_n   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/csp_ctrl_bank.sv
module csp_ctrl_bank #(
    parameter int NREG   = 3,
    parameter int BASE   = 1,
    parameter int AW     = 4,
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic          hit
);
    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [AW-1:0] MY_ADDR = AW'(BASE + g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      regs[g] <= '0;
            else if (we && waddr == MY_ADDR) regs[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        hit   = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            if (raddr == AW'(BASE + i)) begin
                rdata = regs[i];
                hit   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cmdgated_serial_port.sv
module cmdgated_serial_port
    import csp_pkg::*;
#(
    parameter int NCTRL     = 3,
    parameter int CTRL_BASE = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             sdi,
    output logic             sdo,
    output logic             rdy_n,
    input  logic             res_strobe,
    input  logic             res_chan,
    input  logic [RES_W-1:0] res_data
);
    localparam logic [CNT_W-1:0] LAST_RES  = CNT_W'(RES_W - 1);
    localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(CMD_W - 1);

    csp_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [CMD_W-1:0]  rx;
    logic [ADDR_W-1:0] addr;
    logic              is_res;
    logic [RES_W-1:0]  tx;

    logic cs_lvl, cs_rise_unused, cs_fall_unused;
    logic sclk_lvl_unused, sclk_rise, sclk_fall;
    logic sdi_lvl, sdi_rise_unused, sdi_fall_unused;

    csp_pin_sync #(.STAGES(2), .RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .pin(cs_n),
        .level(cs_lvl), .rise(cs_rise_unused), .fall(cs_fall_unused));
    csp_pin_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .pin(sclk),
        .level(sclk_lvl_unused), .rise(sclk_rise), .fall(sclk_fall));
    csp_pin_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sdi_sync (
        .clk(clk), .rst_n(rst_n), .pin(sdi),
        .level(sdi_lvl), .rise(sdi_rise_unused), .fall(sdi_fall_unused));

    logic             cs_act, bit_in;
    logic [CMD_W-1:0] new_byte;
    logic             wr_pulse, read_done;
    logic [RES_W-1:0] rd_word;
    logic [RES_W-1:0] result;
    logic [1:0]       flags;
    logic             upd;
    logic [7:0]       ctrl_rd;
    logic             ctrl_hit;

    assign cs_act   = ~cs_lvl;
    assign bit_in   = cs_act & sclk_rise;
    assign new_byte = {rx[CMD_W-2:0], sdi_lvl};
    assign wr_pulse = bit_in && state == ST_WR && cnt == LAST_BYTE;
    assign read_done = bit_in && state == ST_RD && is_res && cnt == LAST_RES;

    csp_ctrl_bank #(.NREG(NCTRL), .BASE(CTRL_BASE), .AW(ADDR_W), .DW(8)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .we(wr_pulse), .waddr(addr), .wdata(new_byte),
        .raddr(new_byte[ADDR_W-1:0]), .rdata(ctrl_rd), .hit(ctrl_hit));

    csp_ready_trk #(.DW(RES_W)) u_ready (
        .clk(clk), .rst_n(rst_n),
        .strobe(res_strobe), .chan(res_chan), .din(res_data),
        .read_done(read_done),
        .result(result), .flags(flags), .upd(upd), .rdy_n(rdy_n));

    always_comb begin
        rd_word = '0;
        if (new_byte[ADDR_W-1:0] == RES_ADDR)       rd_word = result;
        else if (new_byte[ADDR_W-1:0] == STAT_ADDR) rd_word = {6'b0, flags, 16'b0};
        else if (ctrl_hit)                          rd_word = {ctrl_rd, 16'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_CMD;
            cnt    <= '0;
            rx     <= '0;
            addr   <= '0;
            is_res <= 1'b0;
            tx     <= '0;
        end else if (!cs_act) begin
            state <= ST_CMD;
            cnt   <= '0;
        end else if (sclk_rise) begin
            rx  <= new_byte;
            cnt <= cnt + 1'b1;
            unique case (state)
                ST_CMD: if (cnt == LAST_BYTE) begin
                    cnt <= '0;
                    if (!new_byte[7]) begin
                        addr   <= new_byte[ADDR_W-1:0];
                        is_res <= new_byte[ADDR_W-1:0] == RES_ADDR;
                        if (new_byte[6]) begin
                            state <= ST_RD;
                            tx    <= rd_word;
                        end else begin
                            state <= ST_WR;
                        end
                    end
                end
                ST_WR: if (cnt == LAST_BYTE) begin
                    state <= ST_CMD;
                    cnt   <= '0;
                end
                ST_RD: if (cnt == (is_res ? LAST_RES : LAST_BYTE)) begin
                    state <= ST_CMD;
                    cnt   <= '0;
                end
                default: state <= ST_CMD;
            endcase
        end else if (sclk_fall && state == ST_RD && cnt != '0) begin
            tx <= tx << 1;
        end
    end

    always_comb begin
        sdo = (state == ST_RD) ? tx[RES_W-1] : 1'b0;
    end
endmodule

// File: rtl/csp_checker.sv
module csp_checker
    import csp_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cs_lvl,
    input csp_state_t       state,
    input logic             rdy_n,
    input logic             res_strobe,
    input logic             upd,
    input logic             read_done,
    input logic [RES_W-1:0] result,
    input logic [1:0]       flags
);
    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_lvl |=> state == ST_CMD);

    p_pre_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_strobe && !upd) |=> rdy_n);

    p_result_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> $past(rdy_n));

    p_ready_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (!rdy_n && flags != 2'b00));

    p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (read_done && !upd && !res_strobe) |=> (rdy_n && flags == 2'b00));

    p_flag_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_n |-> flags != 2'b00);
endmodule

bind cmdgated_serial_port csp_checker u_csp_checker (
    .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .state(state),
    .rdy_n(rdy_n), .res_strobe(res_strobe), .upd(upd),
    .read_done(read_done), .result(result), .flags(flags));

// File: tb/cmdgated_serial_port_bench.sv
`timescale 1ns/1ps
module cmdgated_serial_port_bench;
    localparam int HP = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
    logic sdo, rdy_n;
    logic res_strobe = 1'b0, res_chan = 1'b0;
    logic [23:0] res_data = '0;

    int total = 0, bad = 0;
    logic [7:0]  m_ctrl [1:3];
    logic [23:0] m_res = '0;
    logic [1:0]  m_flags = '0;
    logic        early_msb;
    logic [23:0] rd;

    always #2 clk = ~clk;

    cmdgated_serial_port u_cmdgated_serial_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .rdy_n(rdy_n), .res_strobe(res_strobe),
        .res_chan(res_chan), .res_data(res_data));

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, output logic o);
        sclk = 1'b0; sdi = b;
        wait_clk(HP);
        o = sdo;
        sclk = 1'b1;
        wait_clk(HP);
    endtask

    task automatic send_byte(input logic [7:0] v);
        logic o;
        for (int i = 7; i >= 0; i--) send_bit(v[i], o);
    endtask

    task automatic xfer(input logic [7:0] cmd, input int nbits, input logic [23:0] wd,
                        input bit hold_cs, output logic [23:0] r);
        logic o;
        cs_n = 1'b0;
        wait_clk(HP);
        send_byte(cmd);
        early_msb = sdo;
        r = '0;
        for (int i = nbits - 1; i >= 0; i--) begin
            send_bit(wd[i], o);
            r[i] = o;
        end
        if (!hold_cs) begin
            cs_n = 1'b1;
            wait_clk(HP);
        end
    endtask

    function automatic logic [7:0] exp_reg(input logic [3:0] a);
        if (a == 4'd0) return {6'b0, m_flags};
        if (a >= 4'd1 && a <= 4'd3) return m_ctrl[a];
        return 8'h00;
    endfunction

    task automatic strobe(input logic ch, input logic [23:0] d);
        @(negedge clk);
        res_strobe = 1'b1; res_chan = ch; res_data = d;
        @(posedge clk); #1;
        res_strobe = 1'b0;
        check("R6 rdy_n high in pre-update cycle", {23'b0, rdy_n}, 24'd1);
        @(posedge clk); #1;
        check("R4 rdy_n low after update", {23'b0, rdy_n}, 24'd0);
        m_res = d;
        m_flags[ch] = 1'b1;
        wait_clk(2);
    endtask

    task automatic read_result(input string tag, input bit hold);
        xfer(8'h44, 24, 24'h0, hold, rd);
        check({tag, " R5/R7 result word"}, rd, m_res);
        check("R9 MSB ready before first falling edge", {23'b0, early_msb}, {23'b0, m_res[23]});
        wait_clk(4);
        check("R5 rdy_n high after result read", {23'b0, rdy_n}, 24'd1);
        m_flags = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] seed_v;
        seed_v = $urandom(32'd20240607);
        for (int i = 1; i <= 3; i++) m_ctrl[i] = 8'h00;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        check("R1 rdy_n after reset", {23'b0, rdy_n}, 24'd1);
        check("R1 sdo idle", {23'b0, sdo}, 24'd0);
        xfer(8'h41, 8, 24'h0, 0, rd);
        check("R1/R3 ctrl1 reset value via first command", {16'b0, rd[7:0]}, 24'h0);

        // R3 read-only status and result, unused address
        xfer(8'h00, 8, 24'hA5, 0, rd);
        xfer(8'h40, 8, 24'h0, 0, rd);
        check("R3 status ignores write", {16'b0, rd[7:0]}, 24'h0);
        xfer(8'h0C, 8, 24'h5A, 0, rd);
        xfer(8'h4C, 8, 24'h0, 0, rd);
        check("R3 unused address reads 0", {16'b0, rd[7:0]}, 24'h0);

        // R4 R5 R6 R7 R8 result path, channel 0 then 1, three-wire frames
        strobe(1'b0, 24'hC3A511);
        xfer(8'h40, 8, 24'h0, 1, rd);
        check("R8 status ch0 flag (3-wire)", {16'b0, rd[7:0]}, 24'h01);
        xfer(8'h40, 8, 24'h0, 1, rd);
        check("R8 status read does not clear", {16'b0, rd[7:0]}, 24'h01);
        read_result("first", 1);
        read_result("repeat", 1);
        strobe(1'b1, 24'h3C0F77);
        strobe(1'b0, 24'h81FF02);
        xfer(8'h40, 8, 24'h0, 1, rd);
        check("R8 status both flags", {16'b0, rd[7:0]}, 24'h03);
        read_result("latest", 1);
        xfer(8'h40, 8, 24'h0, 1, rd);
        check("R5 flags clear after result read", {16'b0, rd[7:0]}, 24'h00);
        cs_n = 1'b1;
        wait_clk(HP);

        // R2 ignored command byte followed by a real command in one frame
        xfer(8'h02, 8, 24'h6E, 0, rd);
        m_ctrl[2] = 8'h6E;
        cs_n = 1'b0;
        wait_clk(HP);
        send_byte(8'hC2);
        xfer(8'h42, 8, 24'h0, 0, rd);
        check("R2 bit7 byte ignored, next byte is command", {16'b0, rd[7:0]}, 24'h6E);

        // R10 abort mid write
        cs_n = 1'b0;
        wait_clk(HP);
        send_byte(8'h02);
        for (int i = 0; i < 4; i++) begin
            logic o;
            send_bit(1'b1, o);
        end
        cs_n = 1'b1;
        wait_clk(HP);
        xfer(8'h42, 8, 24'h0, 0, rd);
        check("R10 aborted write leaves register", {16'b0, rd[7:0]}, 24'h6E);

        // random mix against the bench model
        for (int k = 0; k < 40; k++) begin
            int op;
            logic [3:0] a;
            logic [7:0] d;
            op = $urandom_range(0, 3);
            a  = 4'($urandom_range(1, 3));
            d  = 8'($urandom);
            unique case (op)
                0: begin
                    xfer({4'h0, a}, 8, {16'b0, d}, 0, rd);
                    m_ctrl[a] = d;
                end
                1: begin
                    xfer({4'h4, a}, 8, 24'h0, 0, rd);
                    check("R3 random control read", {16'b0, rd[7:0]}, {16'b0, exp_reg(a)});
                end
                2: begin
                    xfer(8'h40, 8, 24'h0, 0, rd);
                    check("R8 random status read", {16'b0, rd[7:0]}, {16'b0, exp_reg(4'd0)});
                end
                default: begin
                    strobe(1'($urandom_range(0, 1)), 24'($urandom));
                    if ($urandom_range(0, 1) == 1) read_result("random", 0);
                end
            endcase
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule